// File: doc/BRIEF.md
# Byte-Lane Load/Store Bus Master

This block sits between a simple processor-side load/store port and a synchronous, word-wide memory-mapped bus. A requester presents a 32-bit byte address, an access size (byte, half-word or word), a write flag and store data. The block turns this into one bus access. The bus access carries a word address, a byte-enable mask, a read line and lane-steered write data. The block announces the access with a one-cycle enable pulse. It then waits for the device to acknowledge.

On the acknowledge edge the block captures the read word. It moves the enabled lanes down to bit 0 and zero-extends the result. It then hands the value back with a one-cycle completion pulse. Only one access is in flight at a time, and the requester sees this through a ready/busy pair.

Misaligned requests never reach the bus. They complete at once with an error flag.

Top module: `lsu_bus_master`

## Requirements
- R1: The bus word address equals bits 31..2 of the accepted byte address; the two low bits never reach the bus.
- R2: Size code 0 is a byte, 1 a half-word, 2 a word. A byte at offset k enables only bit k of the enable mask. A half-word at offset 0 enables 0011 and at offset 2 enables 1100. A word enables 1111. Enable bit n covers data bits 8n+7..8n.
- R3: Store data is steered onto the lanes: a byte is copied to all four lanes, a half-word to both halves, and a word goes out unchanged.
- R4: The read line is 1 for a load and 0 for a store. Address, enables, read line and write data are valid while the enable pulse is high and stay unchanged until the acknowledge edge.
- R5: The bus enable is high for exactly one cycle, namely the cycle after the request is accepted.
- R6: Read data is sampled only on the rising edge where the acknowledge is 1. In the cycle after that edge, done pulses for one cycle. The load result is the addressed bytes moved to bit 0 and zero-extended. A store returns 0.
- R7: From the cycle after a good request is accepted until the acknowledge edge, busy is 1 and ready is 0. No second bus access starts in that window.
- R8: A half-word at an odd address, a word at a non-zero offset, or size code 3 is rejected. In the next cycle done and error are both 1, the result is 0, and no bus enable is issued.
- R9: An acknowledge while no access is pending is ignored: it produces no done, no busy and no bus enable.
- R10: After reset, bus enable, busy and done are 0 and ready is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Requester presents an access |
| req_ready | output | 1 | Block can accept an access this cycle |
| req_write | input | 1 | 1 = store, 0 = load |
| req_size | input | 2 | 0 byte, 1 half-word, 2 word, 3 illegal |
| req_addr | input | 32 | Byte address |
| req_wdata | input | 32 | Store data, right-aligned |
| busy | output | 1 | An access is waiting for acknowledge |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_err | output | 1 | Completion was a rejected misaligned access |
| rsp_rdata | output | 32 | Load result, zero-extended |
| bus_addr | output | 30 | Word address |
| bus_ben | output | 4 | Byte-lane enables |
| bus_rd | output | 1 | 1 = read, 0 = write |
| bus_en | output | 1 | One-cycle access start pulse |
| bus_wdata | output | 32 | Lane-steered write data |
| bus_rdata | input | 32 | Device read data |
| bus_ack | input | 1 | Device acknowledge |

## Verification
The bus fields and the enable pulse are due one cycle after the accepting edge. A rejected request shows done and error in that same cycle. A good access shows done one cycle after the edge on which the acknowledge is sampled. The device model varies that latency from 0 to 7 cycles and drives junk read data outside the acknowledge cycle. Inputs change on falling edges. The driver checks busy, enable and ready at the first falling edge after acceptance. The device model checks the bus fields at the falling edge where it first sees the enable, and checks that the enable is low one falling edge later. The scoreboard monitor compares each done pulse at its falling edge with the oldest queued expectation.

// File: rtl/lsu_pkg.sv
`timescale 1ns/1ps
package lsu_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_RSVD = 2'd3
  } lsu_size_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_WAIT = 1'b1
  } lsu_state_e;

  // Number of bytes named by a size code.
  function automatic int size_bytes(input logic [1:0] sz);
    return 1 << sz;
  endfunction

endpackage

// File: rtl/lsu_lane_decode.sv
`timescale 1ns/1ps
module lsu_lane_decode #(
  parameter int LANES = 4,
  parameter int OFF_W = 2
) (
  input  logic [1:0]       size_i,
  input  logic [OFF_W-1:0] off_i,
  output logic [LANES-1:0] ben_o,
  output logic             legal_o
);
  import lsu_pkg::*;

  int nbytes;
  int offset;

  always_comb begin
    nbytes  = size_bytes(size_i);
    offset  = int'(off_i);
    legal_o = (nbytes <= LANES) && ((offset % nbytes) == 0);
  end

  for (genvar n = 0; n < LANES; n++) begin : g_lane
    assign ben_o[n] = legal_o && (n >= offset) && (n < offset + nbytes);
  end

endmodule

// File: rtl/lsu_store_steer.sv
`timescale 1ns/1ps
module lsu_store_steer #(
  parameter int DATA_W = 32,
  parameter int LANES  = DATA_W / 8
) (
  input  logic [1:0]        size_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] data_o
);
  import lsu_pkg::*;

  function automatic logic [7:0] pick_byte(input logic [DATA_W-1:0] w, input int idx);
    return w[8*idx +: 8];
  endfunction

  function automatic int span(input logic [1:0] sz);
    int nb;
    nb = size_bytes(sz);
    return (nb > LANES) ? LANES : nb;
  endfunction

  // Each lane repeats the source byte its position modulo the access size.
  for (genvar n = 0; n < LANES; n++) begin : g_lane
    assign data_o[8*n +: 8] = pick_byte(data_i, n % span(size_i));
  end

endmodule

// File: rtl/lsu_load_steer.sv
`timescale 1ns/1ps
module lsu_load_steer #(
  parameter int DATA_W = 32,
  parameter int LANES  = DATA_W / 8,
  parameter int OFF_W  = $clog2(LANES)
) (
  input  logic [1:0]        size_i,
  input  logic [OFF_W-1:0]  off_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] data_o
);
  import lsu_pkg::*;

  function automatic logic [7:0] pick_byte(input logic [DATA_W-1:0] w, input int idx);
    logic [7:0] b;
    b = 8'h00;
    for (int k = 0; k < LANES; k++) begin
      if (k == idx) b = w[8*k +: 8];
    end
    return b;
  endfunction

  // Result lane n takes bus lane n+offset while n is inside the access.
  for (genvar n = 0; n < LANES; n++) begin : g_lane
    assign data_o[8*n +: 8] =
      (n < size_bytes(size_i)) ? pick_byte(data_i, n + int'(off_i)) : 8'h00;
  end

endmodule

// File: rtl/lsu_bus_master.sv
`timescale 1ns/1ps
module lsu_bus_master #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        req_valid,
  output logic                        req_ready,
  input  logic                        req_write,
  input  logic [1:0]                  req_size,
  input  logic [ADDR_W-1:0]           req_addr,
  input  logic [DATA_W-1:0]           req_wdata,
  output logic                        busy,
  output logic                        rsp_done,
  output logic                        rsp_err,
  output logic [DATA_W-1:0]           rsp_rdata,
  output logic [ADDR_W-$clog2(DATA_W/8)-1:0] bus_addr,
  output logic [DATA_W/8-1:0]         bus_ben,
  output logic                        bus_rd,
  output logic                        bus_en,
  output logic [DATA_W-1:0]           bus_wdata,
  input  logic [DATA_W-1:0]           bus_rdata,
  input  logic                        bus_ack
);
  import lsu_pkg::*;

  localparam int LANES   = DATA_W / 8;
  localparam int OFF_W   = $clog2(LANES);
  localparam int WADDR_W = ADDR_W - OFF_W;

  lsu_state_e        state;
  logic [OFF_W-1:0]  req_off;
  logic [OFF_W-1:0]  off_q;
  logic [1:0]        size_q;
  logic [LANES-1:0]  ben_d;
  logic              legal_d;
  logic [DATA_W-1:0] wdata_d;
  logic [DATA_W-1:0] load_data;

  // Named events used by the checker.
  logic accept;
  logic start_ok;
  logic start_bad;
  logic ack_edge;

  assign req_off   = req_addr[OFF_W-1:0];
  assign busy      = (state == ST_WAIT);
  assign req_ready = !busy;
  assign accept    = req_valid && req_ready;
  assign start_ok  = accept && legal_d;
  assign start_bad = accept && !legal_d;
  assign ack_edge  = busy && bus_ack;

  lsu_lane_decode #(.LANES(LANES), .OFF_W(OFF_W)) u_dec (
    .size_i (req_size),
    .off_i  (req_off),
    .ben_o  (ben_d),
    .legal_o(legal_d)
  );

  lsu_store_steer #(.DATA_W(DATA_W), .LANES(LANES)) u_st (
    .size_i(req_size),
    .data_i(req_wdata),
    .data_o(wdata_d)
  );

  lsu_load_steer #(.DATA_W(DATA_W), .LANES(LANES), .OFF_W(OFF_W)) u_ld (
    .size_i(size_q),
    .off_i (off_q),
    .data_i(bus_rdata),
    .data_o(load_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      bus_addr  <= '0;
      bus_ben   <= '0;
      bus_rd    <= 1'b0;
      bus_wdata <= '0;
      bus_en    <= 1'b0;
      off_q     <= '0;
      size_q    <= '0;
      rsp_done  <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      bus_en   <= 1'b0;
      rsp_done <= 1'b0;
      rsp_err  <= 1'b0;
      if (start_ok) begin
        state     <= ST_WAIT;
        bus_addr  <= req_addr[ADDR_W-1:OFF_W];
        bus_ben   <= ben_d;
        bus_rd    <= !req_write;
        bus_wdata <= wdata_d;
        bus_en    <= 1'b1;
        off_q     <= req_off;
        size_q    <= req_size;
      end else if (start_bad) begin
        rsp_done  <= 1'b1;
        rsp_err   <= 1'b1;
        rsp_rdata <= '0;
      end else if (ack_edge) begin
        state     <= ST_IDLE;
        rsp_done  <= 1'b1;
        rsp_rdata <= bus_rd ? load_data : '0;
      end
    end
  end

endmodule

// File: rtl/lsu_bus_checker.sv
`timescale 1ns/1ps
module lsu_bus_checker #(
  parameter int LANES   = 4,
  parameter int WADDR_W = 30,
  parameter int DATA_W  = 32
) (
  input logic               clk,
  input logic               rst_n,
  input logic               bus_en,
  input logic               bus_ack,
  input logic               busy,
  input logic [WADDR_W-1:0] bus_addr,
  input logic [LANES-1:0]   bus_ben,
  input logic               bus_rd,
  input logic [DATA_W-1:0]  bus_wdata,
  input logic               rsp_done,
  input logic               rsp_err,
  input logic               start_bad,
  input logic               ack_edge
);

  AST_EN_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    bus_en |=> !bus_en); // R5

  AST_EN_ONLY_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    bus_en |-> busy); // R7

  AST_FIELDS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !bus_ack) |=> ($stable(bus_addr) && $stable(bus_ben)
                           && $stable(bus_rd) && $stable(bus_wdata))); // R4

  AST_BEN_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
    bus_en |-> ($countones(bus_ben) == 1 || $countones(bus_ben) == 2
                || $countones(bus_ben) == LANES)); // R2

  AST_DONE_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    ack_edge |=> (rsp_done && !rsp_err && !busy)); // R6

  AST_REJECT_NO_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    start_bad |=> (rsp_done && rsp_err && !bus_en && !busy)); // R8

  AST_IDLE_ACK_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start_bad) |=> !rsp_done); // R9

endmodule

bind lsu_bus_master lsu_bus_checker #(
  .LANES(LANES), .WADDR_W(WADDR_W), .DATA_W(DATA_W)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .bus_en   (bus_en),
  .bus_ack  (bus_ack),
  .busy     (busy),
  .bus_addr (bus_addr),
  .bus_ben  (bus_ben),
  .bus_rd   (bus_rd),
  .bus_wdata(bus_wdata),
  .rsp_done (rsp_done),
  .rsp_err  (rsp_err),
  .start_bad(start_bad),
  .ack_edge (ack_edge)
);

// File: tb/sim_lsu_bus_master.sv
`timescale 1ns/1ps
module sim_lsu_bus_master;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [1:0]  req_size = 2'd0;
  logic [31:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        busy, rsp_done, rsp_err;
  logic [31:0] rsp_rdata;
  logic [29:0] bus_addr;
  logic [3:0]  bus_ben;
  logic        bus_rd, bus_en;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata = 32'hDEAD_BEEF;
  logic        bus_ack = 1'b0;

  int checks = 0;
  int fails  = 0;
  int dones  = 0;
  int dev_lat = 0;

  typedef struct {
    logic [29:0] addr;
    logic [3:0]  ben;
    logic        rd;
    logic [31:0] wd;
  } bus_item_t;

  typedef struct {
    logic        err;
    logic [31:0] data;
  } rsp_item_t;

  bus_item_t bq[$];
  rsp_item_t rq[$];
  logic [31:0] shadow [16];
  logic [31:0] dev_mem [16];

  always #2.5 clk = ~clk;

  lsu_bus_master u0 (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_size(req_size), .req_addr(req_addr), .req_wdata(req_wdata),
    .busy(busy), .rsp_done(rsp_done), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
    .bus_addr(bus_addr), .bus_ben(bus_ben), .bus_rd(bus_rd), .bus_en(bus_en),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ack(bus_ack)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  // Reference lane rules written independently of the design.
  function automatic logic [3:0] ref_ben(input logic [1:0] sz, input logic [1:0] off);
    case (sz)
      2'd0:    return 4'b0001 << off;
      2'd1:    return off[1] ? 4'b1100 : 4'b0011;
      default: return 4'b1111;
    endcase
  endfunction

  function automatic logic [31:0] ref_spread(input logic [1:0] sz, input logic [31:0] d);
    case (sz)
      2'd0:    return {4{d[7:0]}};
      2'd1:    return {2{d[15:0]}};
      default: return d;
    endcase
  endfunction

  function automatic logic [31:0] ref_extract(input logic [1:0] sz, input logic [1:0] off,
                                              input logic [31:0] w);
    logic [31:0] s;
    s = w >> (8 * off);
    case (sz)
      2'd0:    return {24'h0, s[7:0]};
      2'd1:    return {16'h0, s[15:0]};
      default: return s;
    endcase
  endfunction

  // Driver: queue expectations, then present the request.
  task automatic issue(input logic wr, input logic [1:0] sz, input logic [31:0] addr,
                       input logic [31:0] wd, input int lat);
    logic [1:0]  off;
    logic        ok;
    logic [3:0]  be;
    logic [31:0] sp;
    int          idx;
    int          target;
    bus_item_t   bi;
    rsp_item_t   ri;
    off = addr[1:0];
    ok  = (sz == 2'd0) || (sz == 2'd1 && !off[0]) || (sz == 2'd2 && off == 2'd0);
    idx = int'(addr[5:2]);
    be  = ref_ben(sz, off);
    sp  = ref_spread(sz, wd);
    if (ok) begin
      bi.addr = addr[31:2]; bi.ben = be; bi.rd = !wr; bi.wd = sp;
      bq.push_back(bi);
      ri.err = 1'b0;
      if (wr) begin
        for (int b = 0; b < 4; b++) if (be[b]) shadow[idx][8*b +: 8] = sp[8*b +: 8];
        ri.data = '0;
      end else begin
        ri.data = ref_extract(sz, off, shadow[idx]);
      end
    end else begin
      ri.err = 1'b1; ri.data = '0;
    end
    rq.push_back(ri);
    target = dones + 1;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    dev_lat   = lat;
    req_write = wr; req_size = sz; req_addr = addr; req_wdata = wd;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    check("R5 bus_en one cycle after accept", {31'h0, bus_en}, {31'h0, ok});
    check("R7 busy after accept", {31'h0, busy}, {31'h0, ok});
    if (ok) check("R7 ready low while pending", {31'h0, req_ready}, 32'h0);
    while (dones < target) @(negedge clk);
  endtask

  // Monitor: compare each done pulse with the oldest expectation.
  always @(negedge clk) begin
    if (rst_n && rsp_done) begin
      dones++;
      if (rq.size() == 0) begin
        check("R9 unexpected done", 32'h1, 32'h0);
      end else begin
        rsp_item_t e;
        e = rq.pop_front();
        check("R8 error flag", {31'h0, rsp_err}, {31'h0, e.err});
        check("R6 result data", rsp_rdata, e.data);
      end
    end
  end

  // Device model with programmable acknowledge latency.
  logic      en_prev = 1'b0;
  logic      pending = 1'b0;
  int        cnt = 0;
  bus_item_t cur;
  always @(negedge clk) begin
    if (bus_ack) begin
      bus_ack   = 1'b0;
      bus_rdata = 32'hDEAD_BEEF;
    end
    if (en_prev) check("R5 bus_en dropped", {31'h0, bus_en}, 32'h0);
    en_prev = bus_en;
    if (rst_n && bus_en) begin
      if (bq.size() == 0) begin
        check("R8 unexpected bus access", 32'h1, 32'h0);
      end else begin
        bus_item_t e;
        e = bq.pop_front();
        check("R1 word address", {2'b0, bus_addr}, {2'b0, e.addr});
        check("R2 byte enables", {28'h0, bus_ben}, {28'h0, e.ben});
        check("R4 read line", {31'h0, bus_rd}, {31'h0, e.rd});
        if (!e.rd) check("R3 lane data", bus_wdata, e.wd);
      end
      cur.addr = bus_addr; cur.ben = bus_ben; cur.rd = bus_rd; cur.wd = bus_wdata;
      pending = 1'b1;
      cnt = dev_lat;
    end
    if (pending) begin
      if (cnt == 0) begin
        if (cur.rd) bus_rdata = dev_mem[cur.addr[3:0]];
        else for (int b = 0; b < 4; b++)
          if (cur.ben[b]) dev_mem[cur.addr[3:0]][8*b +: 8] = cur.wd[8*b +: 8];
        bus_ack = 1'b1;
        pending = 1'b0;
      end else begin
        if (bus_addr != cur.addr || bus_ben != cur.ben)
          check("R4 fields held", {2'b0, bus_addr}, {2'b0, cur.addr});
        cnt--;
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) begin shadow[i] = '0; dev_mem[i] = '0; end
    repeat (3) @(negedge clk);
    check("R10 reset bus_en", {31'h0, bus_en}, 32'h0);
    check("R10 reset busy", {31'h0, busy}, 32'h0);
    check("R10 reset ready", {31'h0, req_ready}, 32'h1);
    check("R10 reset done", {31'h0, rsp_done}, 32'h0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R1 R3 R6: word store and load
    issue(1'b1, 2'd2, 32'h0000_0010, 32'h1122_3344, 0);
    issue(1'b0, 2'd2, 32'h0000_0010, 32'h0, 1);
    // R2 R6: every byte and half-word position
    for (int k = 0; k < 4; k++) issue(1'b0, 2'd0, 32'h0000_0010 + k, 32'h0, k);
    issue(1'b0, 2'd1, 32'h0000_0010, 32'h0, 2);
    issue(1'b0, 2'd1, 32'h0000_0012, 32'h0, 0);
    // R3: byte and half-word stores onto lanes
    issue(1'b1, 2'd0, 32'h0000_0021, 32'hFFFF_FFAB, 3);
    issue(1'b1, 2'd1, 32'h0000_0022, 32'h1234_BEEF, 1);
    issue(1'b0, 2'd2, 32'h0000_0020, 32'h0, 7);
    issue(1'b1, 2'd0, 32'h0000_0033, 32'h0000_005A, 0);
    issue(1'b0, 2'd0, 32'h0000_0033, 32'h0, 5);
    // R1: high address bits pass through
    issue(1'b1, 2'd2, 32'hFFFF_FFC8, 32'hCAFE_F00D, 2);
    issue(1'b0, 2'd1, 32'hFFFF_FFCA, 32'h0, 0);
    // R8: misaligned and reserved requests
    issue(1'b0, 2'd1, 32'h0000_0011, 32'h0, 0);
    issue(1'b1, 2'd2, 32'h0000_0012, 32'h5555_5555, 0);
    issue(1'b0, 2'd3, 32'h0000_0010, 32'h0, 0);
    // R9: spurious acknowledge while idle
    @(negedge clk);
    bus_ack = 1'b1;
    @(negedge clk);
    bus_ack = 1'b0;
    for (int c = 0; c < 3; c++) begin
      check("R9 no done on idle ack", {31'h0, rsp_done}, 32'h0);
      check("R9 no busy on idle ack", {31'h0, busy}, 32'h0);
      @(negedge clk);
    end
    // R8: the rejected store left memory unchanged
    issue(1'b0, 2'd2, 32'h0000_0010, 32'h0, 1);

    repeat (3) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule